// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block collects up to 32 interrupt request lines, records each request in a sticky status register and qualifies it with a per-source enable mask. It gives the processor a single interrupt line and a vector register that names the source to service. Each source's sense is fixed when the block is built. A parameter bit of one makes the source capture rising edges. A bit of zero makes it capture a high level.

Software reaches the block over a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe with registered read data. The bus is a control path, so it has no valid/ready handshake. Every access completes in one cycle and nothing is ever back-pressured. Write-one registers let software change single enable bits without a read-modify-write sequence. A write-one acknowledge register retires serviced requests, and a two-bit master enable gates the output line.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the status, enable and master enable registers are zero, `irq_out` is low and `bus_rdata` is zero; the vector register reads 0xFFFFFFFF.
- R2: A source whose `SENSE_EDGE` bit is 1 sets its status bit only on a 0-to-1 change of its input; a source whose bit is 0 sets it every cycle its input is high; once set, a status bit stays set until acknowledged (status reads at byte offset 0x00).
- R3: A write to offset 0x0C clears each status bit whose written bit is 1; if a source raises a new request in the same cycle, its status bit stays set.
- R4: A write to offset 0x08 replaces the whole enable mask, and a read of 0x08 returns it.
- R5: A write to offset 0x10 sets each enable bit whose written bit is 1 and leaves the others unchanged.
- R6: A write to offset 0x14 clears each enable bit whose written bit is 1 and leaves the others unchanged.
- R7: A read of offset 0x04 returns status AND enable.
- R8: A read of offset 0x18 returns the lowest-numbered bit index set in the 0x04 value, or 0xFFFFFFFF when that value is zero.
- R9: Offset 0x1C holds a two-bit master enable in bits [1:0] and reads back zero-extended; `irq_out` is high only when both bits are 1 and the 0x04 value is nonzero.
- R10: Reads of offsets 0x0C, 0x10 and 0x14 return zero.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds its value in every other cycle; address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt request lines, one per source |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench holds one edge source high and one level source high while it acknowledges every bit at once. A design that mixed up the two senses, or let the acknowledge beat a live level request, would show the wrong status pattern afterwards. It has two enabled sources pending at the same time and retires them one by one. An encoder that picked the highest source, or left a stale number behind, would report the wrong vector, and an empty mask must give all ones. It also writes one master bit without the other, where a controller that gated on either bit would raise the line too early. It reads the write-only registers, where stale data would appear, and leaves the read strobe low while the state changes, where read data that does not hold would move.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word index within the register window (byte address bits [4:2]).
  typedef enum logic [2:0] {
    RG_STAT = 3'd0,
    RG_PEND = 3'd1,
    RG_MASK = 3'd2,
    RG_ACK  = 3'd3,
    RG_MSET = 3'd4,
    RG_MCLR = 3'd5,
    RG_VEC  = 3'd6,
    RG_MEN  = 3'd7
  } vic_reg_e;

  localparam int unsigned MEN_BITS = 2;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned NSRC = 32,
  parameter logic [NSRC-1:0] SENSE_EDGE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] status
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (SENSE_EDGE[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[i];
      end
      assign hit[i] = irq_in[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = irq_in[i];
    end
  end

  // A new request beats an acknowledge of the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~ack_clr) | hit;
  end

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_clr) |=> ((status & $past(ack_clr & ~hit)) == '0));
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr == '0) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/vic_mask.sv
module vic_mask #(
  parameter int unsigned NSRC = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_mask,
  input  logic                         we_set,
  input  logic                         we_clr,
  input  logic                         we_men,
  input  logic [NSRC-1:0]              wdata,
  output logic [NSRC-1:0]              mask,
  output logic [vic_pkg::MEN_BITS-1:0] men
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      men  <= '0;
    end else begin
      if (we_mask)     mask <= wdata;
      else if (we_set) mask <= mask | wdata;
      else if (we_clr) mask <= mask & ~wdata;
      if (we_men)      men  <= wdata[vic_pkg::MEN_BITS-1:0];
    end
  end

  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((mask & $past(wdata)) == $past(wdata)));
  a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((mask & $past(wdata)) == '0));
  a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] vec,
  output logic            any
);
  localparam int unsigned VW = $clog2(NSRC);

  // Scan downward so that the lowest set index is the last one written.
  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = NSRC'(i);
    end
  end

  assign any = |pend;

  a_r8_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> pend[vec[VW-1:0]]);
  a_r8_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> ((pend & ((NSRC'(1) << vec[VW-1:0]) - NSRC'(1))) == '0));
  a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vec == '1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW = 5,
  parameter logic [NSRC-1:0] SENSE_EDGE = 32'h0000_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NSRC-1:0] bus_wdata,
  input  logic            bus_rd,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_out
);
  import vic_pkg::*;

  localparam int unsigned MW = MEN_BITS;

  vic_reg_e        sel;
  logic [NSRC-1:0] status, mask, pend, vec, ack_clr, rd_mux;
  logic [MW-1:0]   men;
  logic            any;
  logic            unused_lsb;

  assign sel        = vic_reg_e'(bus_addr[AW-1:2]);
  assign unused_lsb = ^bus_addr[1:0];
  assign ack_clr    = (bus_wr && sel == RG_ACK) ? bus_wdata : '0;

  vic_capture #(.NSRC(NSRC), .SENSE_EDGE(SENSE_EDGE)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr),
    .status(status));

  vic_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .we_mask(bus_wr && sel == RG_MASK),
    .we_set (bus_wr && sel == RG_MSET),
    .we_clr (bus_wr && sel == RG_MCLR),
    .we_men (bus_wr && sel == RG_MEN),
    .wdata(bus_wdata), .mask(mask), .men(men));

  assign pend = status & mask;

  vic_prio #(.NSRC(NSRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .vec(vec), .any(any));

  assign irq_out = any & (&men);

  always_comb begin
    unique case (sel)
      RG_STAT: rd_mux = status;
      RG_PEND: rd_mux = pend;
      RG_MASK: rd_mux = mask;
      RG_VEC:  rd_mux = vec;
      RG_MEN:  rd_mux = {{(NSRC-MW){1'b0}}, men};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r9_out_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec != '1));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  a_r10_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel == RG_ACK || sel == RG_MSET || sel == RG_MCLR))
      |=> (bus_rdata == '0));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_MASK = 5'h08,
    A_ACK = 5'h0C, A_MSET = 5'h10, A_MCLR = 5'h14, A_VEC = 5'h18, A_MEN = 5'h1C;

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_MASK, d); chk("R1 enable", d, 32'h0);
    rd(A_MEN, d);  chk("R1 master", d, 32'h0);
    rd(A_VEC, d);  chk("R1 vector", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_sense();
    logic [31:0] d;
    pulse(32'h0010_0000);                       // level source 20, one cycle
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R2 level sticky", d, 32'h0010_0000);
    chk("R9 no irq without enable", {31'b0, irq_out}, 32'h0);
    @(negedge clk); irq_in = 32'h0020_0008;     // edge 3 and level 21 held
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R2 edge+level capture", d, 32'h0030_0008);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R3 ack vs live level", d, 32'h0020_0000);
    @(negedge clk); irq_in = '0;
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R3 ack all", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_MASK, 32'h0000_00F0);
    rd(A_MASK, d); chk("R4 direct write", d, 32'h0000_00F0);
    wr(A_MSET, 32'h0000_0003);
    rd(A_MASK, d); chk("R5 set-enable", d, 32'h0000_00F3);
    wr(A_MCLR, 32'h0000_0030);
    rd(A_MASK, d); chk("R6 clear-enable", d, 32'h0000_00C3);
    rd(A_ACK, d);  chk("R10 ack reads 0", d, 32'h0);
    rd(A_MSET, d); chk("R10 set reads 0", d, 32'h0);
    rd(A_MCLR, d); chk("R10 clr reads 0", d, 32'h0);
    wr(A_MASK, 32'h0);
    rd(A_MASK, d); chk("R4 write zero", d, 32'h0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    pulse(32'h0200_0220);                       // edge 5, 9 and level 25
    wr(A_MASK, 32'h0200_0200);
    rd(A_PEND, d); chk("R7 pending", d, 32'h0200_0200);
    rd(A_VEC, d);  chk("R8 lowest", d, 32'd9);
    chk("R9 master off", {31'b0, irq_out}, 32'h0);
    wr(A_MEN, 32'h1);
    chk("R9 one master bit", {31'b0, irq_out}, 32'h0);
    wr(A_MEN, 32'h3);
    chk("R9 irq asserted", {31'b0, irq_out}, 32'h1);
    rd(A_MEN, d);  chk("R9 master readback", d, 32'h3);
    wr(A_ACK, 32'h0000_0200);
    rd(A_VEC, d);  chk("R8 next source", d, 32'd25);
    wr(A_MCLR, 32'h0200_0000);
    rd(A_VEC, d);  chk("R8 none pending", d, 32'hFFFF_FFFF);
    chk("R9 irq drops", {31'b0, irq_out}, 32'h0);
    rd(A_STAT, d); chk("R7 status kept", d, 32'h0200_0020);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(5'h03, d);  chk("R11 addr lsb ignored", d, 32'h0200_0020);
    wr(A_ACK, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h0200_0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sense();
    t_enable();
    t_vector();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule